// File: doc/BRIEF.md
# Dot-Matrix Display Data Serializer with Cursor Overlay

This block turns the pattern bytes fetched for the two halves of a dot-matrix LCD panel into data lanes for the segment drivers, plus a strobe that marks each shift. An external character-clock phase signal sets the fetch phases. The byte on the pattern bus is captured as the upper-half byte when the phase goes high. It is captured as the lower-half byte when the phase goes low, and that falling edge also starts serialization of the character. A dot enable then paces the shifts.

Three output formats are supported: one bit per lane, two bits per lane and four bits per lane. Only the first Hp bits of each byte, counted from the most significant bit, reach the panel. In character mode a cursor is XORed over the captured byte. This happens when the fetch address equals the cursor address and the raster line lies inside the cursor's line window. The cursor can be off, steady or blinking, and blinking is timed by counting frame ticks. A line-pause input silences the lanes and the strobe. Clearing the display-enable input blanks the lanes while the strobe keeps running.

Top module: `lcd_dot_serializer`

## Requirements
- R1: With `out_mode`=0 (serial), each shift puts the upper byte's current bit on `ud[0]` and the lower byte's on `ud[1]`, MSB first; `ud[3:2]` and `ld` stay 0.
- R2: With `out_mode`=1 (2-bit), each shift puts upper bits D7,D5,D3,D1 on `ud[0]` and D6,D4,D2,D0 on `ud[1]`, and the lower byte the same way on `ud[2]`/`ud[3]`; `ld` stays 0.
- R3: With `out_mode`=2 or 3 (4-bit), the first shift puts upper D7..D4 on `ud[3:0]` and lower D7..D4 on `ld[3:0]`, and the second shift puts D3..D0 there.
- R4: A shift happens on every dot in serial mode, on every second dot in 2-bit mode and on every fourth dot in 4-bit mode, counting from the first dot after the start. Each character makes ceil(Hp/width) shifts, and `shift_pulse` is high for one cycle per shift.
- R5: Hp = `hp_m1`+1; byte bits below the top Hp bits are sent as 0.
- R6: `pat_byte` is captured as the upper byte on the cycle `ch_phase` rises and as the lower byte on the cycle it falls; later bus values do not affect that character.
- R7: With `cur_mode`=2 and `graphics`=0, a captured byte is inverted over its Hp bits when its `pat_addr` equals `cursor_addr` and `cur_start` <= `raster` <= `cur_end` (inclusive, 0-based).
- R8: `cur_mode` 0 or 1 shows no cursor. `cur_mode`=3 blinks: the cursor is visible for the first N frame ticks after reset, hidden for the next N, and so on, with N=16 when `blink_fast`=1 and N=32 otherwise.
- R9: With `graphics`=1 no cursor is applied.
- R10: While `line_pause` is high, no shift happens and the lanes read 0.
- R11: While `disp_on` is low, the lanes read 0 but `shift_pulse` keeps its normal count.
- R12: After reset, `ud`, `ld` and `shift_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dot_en | input | 1 | One-cycle pulse per dot |
| ch_phase | input | 1 | Character phase: low = upper fetch, high = lower fetch |
| pat_byte | input | 8 | Fetched pattern byte |
| pat_addr | input | 16 | Memory address of the byte on `pat_byte` |
| raster | input | 4 | Current raster line within the character row |
| line_pause | input | 1 | High during the end-of-line pause |
| disp_on | input | 1 | Display enable |
| graphics | input | 1 | 1 = graphics mode (no cursor) |
| out_mode | input | 2 | 0 serial, 1 two-bit, 2/3 four-bit |
| hp_m1 | input | 3 | Displayed bits per byte minus one |
| cur_mode | input | 2 | 0/1 off, 2 on, 3 blink |
| blink_fast | input | 1 | Blink half-period: 1 = 16 frames, 0 = 32 |
| cur_start | input | 4 | First cursor raster line |
| cur_end | input | 4 | Last cursor raster line |
| cursor_addr | input | 16 | Cursor character address |
| frame_tick | input | 1 | One pulse per frame |
| ud | output | 4 | Upper-half data lanes |
| ld | output | 4 | Lower-half data lanes |
| shift_pulse | output | 1 | One-cycle shift strobe |

## Verification
The assertions check on every cycle that a pause silences both the strobe and the lanes, and that a cleared display enable blanks the lanes. They also check that lanes unused by the serial and 2-bit formats stay 0, that shifts in the wider formats are never on back-to-back cycles, and that the blink state moves only on a frame tick. Only the bench's scenarios can show the actual bit order on each lane, the Hp truncation, the shift count per character, the cursor window and address match, and the 16- and 32-frame blink periods. These need expected values worked out from the patterns that were sent.

// File: rtl/lcdser_pkg.sv
// Shared encodings for the display data serializer.
package lcdser_pkg;
    typedef enum logic [1:0] {
        OM_SER   = 2'd0,
        OM_PAR2  = 2'd1,
        OM_PAR4  = 2'd2,
        OM_PAR4B = 2'd3
    } outfmt_e;

    typedef enum logic [1:0] {
        CM_OFF0  = 2'd0,
        CM_OFF1  = 2'd1,
        CM_ON    = 2'd2,
        CM_BLINK = 2'd3
    } curmode_e;
endpackage

// File: rtl/lcdser_cursor.sv
// Cursor decision: counts frame ticks for the blink phase and flags when the
// address on the fetch bus lies under a visible cursor.
// Assumes frame_tick is a single-cycle pulse and BLINK_SLOW >= BLINK_FAST >= 2.
module lcdser_cursor
    import lcdser_pkg::*;
#(
    parameter int AW         = 16,
    parameter int RW         = 4,
    parameter int BLINK_FAST = 16,
    parameter int BLINK_SLOW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_tick,
    input  logic          blink_fast,
    input  logic [1:0]    cur_mode,
    input  logic          graphics,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] cursor_addr,
    input  logic [RW-1:0] raster,
    input  logic [RW-1:0] cur_start,
    input  logic [RW-1:0] cur_end,
    output logic          hit,
    output logic          blink_vis
);
    localparam int CW = $clog2(BLINK_SLOW);
    localparam logic [CW-1:0] LIM_F = CW'(BLINK_FAST - 1);
    localparam logic [CW-1:0] LIM_S = CW'(BLINK_SLOW - 1);

    logic [CW-1:0] fcnt;
    logic [CW-1:0] lim;
    logic          shown;
    curmode_e      cm;

    assign cm  = curmode_e'(cur_mode);
    assign lim = blink_fast ? LIM_F : LIM_S;

    // Frame counter; flips the blink phase every lim+1 frame ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt      <= '0;
            blink_vis <= 1'b1;
        end else if (frame_tick) begin
            if (fcnt >= lim) begin
                fcnt      <= '0;
                blink_vis <= ~blink_vis;
            end else begin
                fcnt <= fcnt + 1'b1;
            end
        end
    end

    // Cursor hit for the current fetch address and raster line.
    always_comb begin
        shown = (cm == CM_ON) || ((cm == CM_BLINK) && blink_vis);
        hit   = !graphics && shown && (addr == cursor_addr)
                && (raster >= cur_start) && (raster <= cur_end);
    end
endmodule

// File: rtl/lcdser_capture.sv
// Fetch capture: holds the upper byte on the rising phase edge and the lower
// byte on the falling edge, each XORed with the cursor hit of that moment.
// The falling edge also issues a one-cycle start for the shift engine.
module lcdser_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_phase,
    input  logic [DW-1:0] pat_byte,
    input  logic          hit,
    output logic [DW-1:0] up_hold,
    output logic [DW-1:0] lo_hold,
    output logic          start
);
    logic ch_q;
    logic ph_rise;
    logic ph_fall;

    assign ph_rise = ch_phase && !ch_q;
    assign ph_fall = !ch_phase && ch_q;

    // Edge detection, byte holding and start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q    <= 1'b0;
            up_hold <= '0;
            lo_hold <= '0;
            start   <= 1'b0;
        end else begin
            ch_q  <= ch_phase;
            start <= ph_fall;
            if (ph_rise) up_hold <= pat_byte ^ {DW{hit}};
            if (ph_fall) lo_hold <= pat_byte ^ {DW{hit}};
        end
    end
endmodule

// File: rtl/lcdser_shift.sv
// Shift engine: masks both held bytes to Hp bits, then shifts them out over
// the lanes of the selected format, one shift per 1, 2 or 4 dots.
// Assumes DW >= 4 and that start never coincides with the first dot.
module lcdser_shift
    import lcdser_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   dot_en,
    input  logic [DW-1:0]          up_hold,
    input  logic [DW-1:0]          lo_hold,
    input  logic [$clog2(DW)-1:0]  hp_m1,
    input  logic [1:0]             out_mode,
    input  logic                   line_pause,
    input  logic                   disp_on,
    output logic [3:0]             ud,
    output logic [3:0]             ld,
    output logic                   shift_pulse
);
    localparam int HPW = $clog2(DW);

    outfmt_e        fmt;
    logic [HPW:0]   hp_len;
    logic [DW-1:0]  hp_mask;
    logic [DW-1:0]  su;
    logic [DW-1:0]  sl;
    logic [HPW:0]   dot_cnt;
    logic           busy;
    logic           step_ok;
    logic [2:0]     step;
    logic           do_shift;
    logic [3:0]     ud_n;
    logic [3:0]     ld_n;

    assign fmt     = outfmt_e'(out_mode);
    assign hp_len  = {1'b0, hp_m1} + (HPW+1)'(1);
    assign hp_mask = ~({DW{1'b1}} >> hp_len);

    // Shift cadence and width for the selected format.
    always_comb begin
        case (fmt)
            OM_SER:  begin step = 3'd1; step_ok = 1'b1;              end
            OM_PAR2: begin step = 3'd2; step_ok = !dot_cnt[0];        end
            default: begin step = 3'd4; step_ok = (dot_cnt[1:0] == 2'b00); end
        endcase
        do_shift = dot_en && busy && !line_pause && !start && step_ok
                   && (dot_cnt <= {1'b0, hp_m1});
    end

    // Lane mapping of the shifter heads for each format.
    always_comb begin
        case (fmt)
            OM_SER: begin
                ud_n = {2'b00, sl[DW-1], su[DW-1]};
                ld_n = 4'b0000;
            end
            OM_PAR2: begin
                ud_n = {sl[DW-2], sl[DW-1], su[DW-2], su[DW-1]};
                ld_n = 4'b0000;
            end
            default: begin
                ud_n = su[DW-1:DW-4];
                ld_n = sl[DW-1:DW-4];
            end
        endcase
    end

    // Shifter load, dot counting and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            su      <= '0;
            sl      <= '0;
            dot_cnt <= '0;
            busy    <= 1'b0;
        end else if (start) begin
            su      <= up_hold & hp_mask;
            sl      <= lo_hold & hp_mask;
            dot_cnt <= '0;
            busy    <= !line_pause;
        end else begin
            if (line_pause) begin
                busy <= 1'b0;
            end else if (dot_en && busy) begin
                dot_cnt <= dot_cnt + 1'b1;
                if (dot_cnt == {1'b0, hp_m1}) busy <= 1'b0;
            end
            if (do_shift) begin
                su <= su << step;
                sl <= sl << step;
            end
        end
    end

    // Registered lanes and strobe, blanked by pause or display off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ud          <= '0;
            ld          <= '0;
            shift_pulse <= 1'b0;
        end else begin
            shift_pulse <= do_shift;
            if (line_pause || !disp_on) begin
                ud <= '0;
                ld <= '0;
            end else if (do_shift) begin
                ud <= ud_n;
                ld <= ld_n;
            end
        end
    end
endmodule

// File: rtl/lcd_dot_serializer.sv
// Top of the display data serializer: cursor decision, fetch capture and
// shift engine. Assumes the pattern bus is valid on the phase edges.
module lcd_dot_serializer #(
    parameter int DW         = 8,
    parameter int AW         = 16,
    parameter int RW         = 4,
    parameter int BLINK_FAST = 16,
    parameter int BLINK_SLOW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dot_en,
    input  logic                  ch_phase,
    input  logic [DW-1:0]         pat_byte,
    input  logic [AW-1:0]         pat_addr,
    input  logic [RW-1:0]         raster,
    input  logic                  line_pause,
    input  logic                  disp_on,
    input  logic                  graphics,
    input  logic [1:0]            out_mode,
    input  logic [$clog2(DW)-1:0] hp_m1,
    input  logic [1:0]            cur_mode,
    input  logic                  blink_fast,
    input  logic [RW-1:0]         cur_start,
    input  logic [RW-1:0]         cur_end,
    input  logic [AW-1:0]         cursor_addr,
    input  logic                  frame_tick,
    output logic [3:0]            ud,
    output logic [3:0]            ld,
    output logic                  shift_pulse
);
    logic          cur_hit;
    logic          cur_blink_vis;
    logic [DW-1:0] up_hold;
    logic [DW-1:0] lo_hold;
    logic          ser_start;

    lcdser_cursor #(
        .AW(AW), .RW(RW), .BLINK_FAST(BLINK_FAST), .BLINK_SLOW(BLINK_SLOW)
    ) u_cur (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .blink_fast(blink_fast), .cur_mode(cur_mode), .graphics(graphics),
        .addr(pat_addr), .cursor_addr(cursor_addr), .raster(raster),
        .cur_start(cur_start), .cur_end(cur_end),
        .hit(cur_hit), .blink_vis(cur_blink_vis)
    );

    lcdser_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .ch_phase(ch_phase), .pat_byte(pat_byte),
        .hit(cur_hit), .up_hold(up_hold), .lo_hold(lo_hold), .start(ser_start)
    );

    lcdser_shift #(.DW(DW)) u_shf (
        .clk(clk), .rst_n(rst_n), .start(ser_start), .dot_en(dot_en),
        .up_hold(up_hold), .lo_hold(lo_hold), .hp_m1(hp_m1),
        .out_mode(out_mode), .line_pause(line_pause), .disp_on(disp_on),
        .ud(ud), .ld(ld), .shift_pulse(shift_pulse)
    );
endmodule

// File: rtl/lcdser_checker.sv
// Property checker for the display data serializer, bound to the top.
module lcdser_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       line_pause,
    input logic       disp_on,
    input logic [1:0] out_mode,
    input logic       frame_tick,
    input logic       blink_vis,
    input logic [3:0] ud,
    input logic [3:0] ld,
    input logic       shift_pulse
);
    assert_pause_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_pause |=> (!shift_pulse && ud == 4'd0 && ld == 4'd0));

    assert_off_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> (ud == 4'd0 && ld == 4'd0));

    assert_serial_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && $past(out_mode) == 2'd0) |-> (ud[3:2] == 2'd0 && ld == 4'd0));

    assert_two_bit_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && $past(out_mode) == 2'd1) |-> (ld == 4'd0));

    assert_wide_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && out_mode != 2'd0 && $stable(out_mode)) |=> !shift_pulse);

    assert_blink_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(blink_vis));
endmodule

bind lcd_dot_serializer lcdser_checker u_chk (
    .clk(clk), .rst_n(rst_n), .line_pause(line_pause), .disp_on(disp_on),
    .out_mode(out_mode), .frame_tick(frame_tick), .blink_vis(cur_blink_vis),
    .ud(ud), .ld(ld), .shift_pulse(shift_pulse)
);

// File: tb/tb_lcd_dot_serializer.sv
// Directed bench for the display data serializer.
module tb_lcd_dot_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dot_en = 1'b0;
    logic        ch_phase = 1'b0;
    logic [7:0]  pat_byte = '0;
    logic [15:0] pat_addr = '0;
    logic [3:0]  raster = '0;
    logic        line_pause = 1'b0;
    logic        disp_on = 1'b1;
    logic        graphics = 1'b0;
    logic [1:0]  out_mode = '0;
    logic [2:0]  hp_m1 = 3'd7;
    logic [1:0]  cur_mode = '0;
    logic        blink_fast = 1'b1;
    logic [3:0]  cur_start = 4'd2;
    logic [3:0]  cur_end = 4'd5;
    logic [15:0] cursor_addr = 16'h0100;
    logic        frame_tick = 1'b0;
    logic [3:0]  ud;
    logic [3:0]  ld;
    logic        shift_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int cap_n = 0;
    logic rec = 1'b0;
    logic [3:0] cap_ud [0:15];
    logic [3:0] cap_ld [0:15];

    localparam logic [15:0] HIT = 16'h0100;
    localparam logic [15:0] MISS = 16'h0150;

    always #10 clk = ~clk;

    lcd_dot_serializer dut (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .ch_phase(ch_phase),
        .pat_byte(pat_byte), .pat_addr(pat_addr), .raster(raster),
        .line_pause(line_pause), .disp_on(disp_on), .graphics(graphics),
        .out_mode(out_mode), .hp_m1(hp_m1), .cur_mode(cur_mode),
        .blink_fast(blink_fast), .cur_start(cur_start), .cur_end(cur_end),
        .cursor_addr(cursor_addr), .frame_tick(frame_tick),
        .ud(ud), .ld(ld), .shift_pulse(shift_pulse)
    );

    // Records the lanes at every shift strobe.
    always @(negedge clk) begin
        if (rec && shift_pulse) begin
            if (cap_n < 16) begin
                cap_ud[cap_n] = ud;
                cap_ld[cap_n] = ld;
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            frame_tick = 1'b1; @(negedge clk);
            frame_tick = 1'b0; @(negedge clk);
        end
    endtask

    // One character: upper fetch, lower fetch, then Hp dots.
    task automatic send_char(input [7:0] ub, input [15:0] ua,
                             input [7:0] lb, input [15:0] la);
        int hp;
        hp = int'(hp_m1) + 1;
        cap_n = 0; rec = 1'b1;
        @(negedge clk); ch_phase = 1'b0; pat_byte = ub; pat_addr = ua;
        @(negedge clk); ch_phase = 1'b1;
        @(negedge clk); pat_byte = lb; pat_addr = la;
        @(negedge clk); ch_phase = 1'b0;
        @(negedge clk); pat_byte = 8'h99; pat_addr = 16'hFFFF;
        repeat (2) @(negedge clk);
        for (int i = 0; i < hp; i++) begin
            dot_en = 1'b1; @(negedge clk);
            dot_en = 1'b0; @(negedge clk);
        end
        repeat (2) @(negedge clk);
        rec = 1'b0;
    endtask

    // Compares recorded shifts with the lanes the requirements predict.
    task automatic expect_char(input string tag, input [7:0] eu, input [7:0] el,
                               input bit dark);
        int w, hp, nsh, bad;
        logic [7:0] m, us, ls;
        logic [3:0] eud, eld;
        hp = int'(hp_m1) + 1;
        w = (out_mode == 2'd0) ? 1 : (out_mode == 2'd1) ? 2 : 4;
        nsh = (hp + w - 1) / w;
        m = 8'(8'hFF << (8 - hp));
        bad = -1;
        chk(cap_n == nsh, {tag, " R4 shift count"}, cap_n, nsh);
        for (int j = 0; j < nsh && j < 16; j++) begin
            us = 8'((eu & m) << (j * w));
            ls = 8'((el & m) << (j * w));
            case (out_mode)
                2'd0:    begin eud = {2'b00, ls[7], us[7]}; eld = 4'd0; end
                2'd1:    begin eud = {ls[6], ls[7], us[6], us[7]}; eld = 4'd0; end
                default: begin eud = us[7:4]; eld = ls[7:4]; end
            endcase
            if (dark) begin eud = 4'd0; eld = 4'd0; end
            if (bad < 0 && (cap_ud[j] != eud || cap_ld[j] != eld)) begin
                bad = j;
                chk(1'b0, $sformatf("%s lanes at shift %0d", tag, j),
                    {cap_ud[j], cap_ld[j]}, {eud, eld});
            end
        end
        if (bad < 0) chk(1'b1, tag, 0, 0);
    endtask

    task automatic t_reset();
        chk(ud == 4'd0 && ld == 4'd0 && shift_pulse == 1'b0,
            "R12 reset outputs", {ud, ld, 3'b0, shift_pulse}, 0);
    endtask

    task automatic t_serial();
        out_mode = 2'd0; hp_m1 = 3'd7;
        send_char(8'hA5, MISS, 8'h3C, MISS);
        expect_char("R1 R6 serial A5/3C", 8'hA5, 8'h3C, 1'b0);
        send_char(8'h81, MISS, 8'h7E, MISS);
        expect_char("R1 serial 81/7E", 8'h81, 8'h7E, 1'b0);
    endtask

    task automatic t_par2();
        out_mode = 2'd1; hp_m1 = 3'd7;
        send_char(8'hC9, MISS, 8'h36, MISS);
        expect_char("R2 two-bit C9/36", 8'hC9, 8'h36, 1'b0);
    endtask

    task automatic t_par4();
        out_mode = 2'd2; hp_m1 = 3'd7;
        send_char(8'h5A, MISS, 8'hE1, MISS);
        expect_char("R3 four-bit 5A/E1", 8'h5A, 8'hE1, 1'b0);
        out_mode = 2'd3;
        send_char(8'h3C, MISS, 8'hB4, MISS);
        expect_char("R3 four-bit code 3", 8'h3C, 8'hB4, 1'b0);
    endtask

    task automatic t_trunc();
        out_mode = 2'd0; hp_m1 = 3'd4;
        send_char(8'hFF, MISS, 8'h5F, MISS);
        expect_char("R5 serial Hp5", 8'hFF, 8'h5F, 1'b0);
        out_mode = 2'd2; hp_m1 = 3'd5;
        send_char(8'hB7, MISS, 8'h6D, MISS);
        expect_char("R5 four-bit Hp6", 8'hB7, 8'h6D, 1'b0);
        out_mode = 2'd1; hp_m1 = 3'd6;
        send_char(8'hFF, MISS, 8'hAB, MISS);
        expect_char("R5 two-bit Hp7", 8'hFF, 8'hAB, 1'b0);
    endtask

    task automatic t_cursor();
        out_mode = 2'd2; hp_m1 = 3'd6; graphics = 1'b0; cur_mode = 2'd2;
        raster = 4'd2;
        send_char(8'h12, HIT, 8'h34, MISS);
        expect_char("R7 cursor upper at start line", 8'hED, 8'h34, 1'b0);
        raster = 4'd5;
        send_char(8'h12, MISS, 8'h34, HIT);
        expect_char("R7 cursor lower at end line", 8'h12, 8'hCB, 1'b0);
        raster = 4'd6;
        send_char(8'h12, HIT, 8'h34, HIT);
        expect_char("R7 raster past end", 8'h12, 8'h34, 1'b0);
        raster = 4'd1;
        send_char(8'h12, HIT, 8'h34, HIT);
        expect_char("R7 raster before start", 8'h12, 8'h34, 1'b0);
    endtask

    task automatic t_cur_off();
        out_mode = 2'd0; hp_m1 = 3'd7; raster = 4'd3;
        cur_mode = 2'd1;
        send_char(8'h0F, HIT, 8'hF0, HIT);
        expect_char("R8 cursor mode 1 off", 8'h0F, 8'hF0, 1'b0);
        cur_mode = 2'd0;
        send_char(8'h0F, HIT, 8'hF0, HIT);
        expect_char("R8 cursor mode 0 off", 8'h0F, 8'hF0, 1'b0);
        cur_mode = 2'd2; graphics = 1'b1;
        send_char(8'h0F, HIT, 8'hF0, HIT);
        expect_char("R9 graphics no cursor", 8'h0F, 8'hF0, 1'b0);
        graphics = 1'b0;
    endtask

    task automatic t_blink();
        out_mode = 2'd2; hp_m1 = 3'd7; raster = 4'd3; cur_mode = 2'd3;
        blink_fast = 1'b1;
        do_reset();
        send_char(8'h0F, HIT, 8'h00, MISS);
        expect_char("R8 blink visible after reset", 8'hF0, 8'h00, 1'b0);
        ticks(15);
        send_char(8'h0F, HIT, 8'h00, MISS);
        expect_char("R8 fast blink 15 ticks visible", 8'hF0, 8'h00, 1'b0);
        ticks(1);
        send_char(8'h0F, HIT, 8'h00, MISS);
        expect_char("R8 fast blink 16 ticks hidden", 8'h0F, 8'h00, 1'b0);
        ticks(16);
        send_char(8'h0F, HIT, 8'h00, MISS);
        expect_char("R8 fast blink 32 ticks visible", 8'hF0, 8'h00, 1'b0);
        blink_fast = 1'b0;
        do_reset();
        ticks(16);
        send_char(8'h0F, HIT, 8'h00, MISS);
        expect_char("R8 slow blink 16 ticks visible", 8'hF0, 8'h00, 1'b0);
        ticks(16);
        send_char(8'h0F, HIT, 8'h00, MISS);
        expect_char("R8 slow blink 32 ticks hidden", 8'h0F, 8'h00, 1'b0);
        cur_mode = 2'd0;
    endtask

    task automatic t_pause();
        out_mode = 2'd0; hp_m1 = 3'd7;
        line_pause = 1'b1;
        send_char(8'hFF, MISS, 8'hFF, MISS);
        chk(cap_n == 0, "R10 no shifts in pause", cap_n, 0);
        chk(ud == 4'd0 && ld == 4'd0, "R10 lanes zero in pause", {ud, ld}, 0);
        line_pause = 1'b0;
    endtask

    task automatic t_dark();
        out_mode = 2'd1; hp_m1 = 3'd7;
        disp_on = 1'b0;
        send_char(8'hFF, MISS, 8'hFF, MISS);
        expect_char("R11 display off", 8'hFF, 8'hFF, 1'b1);
        disp_on = 1'b1;
        send_char(8'hFF, MISS, 8'hFF, MISS);
        expect_char("R11 display back on", 8'hFF, 8'hFF, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_serial();
        t_par2();
        t_par4();
        t_trunc();
        t_cursor();
        t_cur_off();
        t_pause();
        t_dark();
        t_blink();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule